// File: doc/BRIEF.md
# Cipher Register Slave

This block sits between a 32-bit memory-mapped host bus and a block cipher engine. The host reaches a small word-addressed window. It writes the key one word per transfer, writes a 128-bit input block as four words, and then writes a single control word. That control word raises a key-stable flag, a data-stable flag and a request to encrypt or to decrypt. The engine reports completion with a one-cycle `core_done` pulse and presents its 128-bit output on `core_dout`. The slave then captures that output into a read-only result area and drops the request bit by itself. It also marks the operation finished.

Software can learn that an operation has finished in two ways. It can poll the pending flag in the control word. It can also enable a level interrupt, which stays high until the next control-word write. The key length (4, 6 or 8 words) and the presence of the decrypt request are compile-time parameters. Every output comes from a register.

Top module: `cipher_reg_slave`

## Requirements
- R1: Word offsets 0 to KEY_WORDS-1 hold the key. Offset k drives `core_key[32k+31:32k]` from the cycle after the write and reads back the written value. Offsets KEY_WORDS to 7 ignore writes and read as 0.
- R2: Offsets 8 to 11 hold the input block. Offset 8+i drives `core_din[32i+31:32i]` and reads back. A write to any of these offsets clears the data-stable flag.
- R3: The control word sits at offset 16 and has these bits: bit 0 encrypt request, bit 1 decrypt request, bit 2 interrupt enable, bit 3 key-stable, bit 4 data-stable, bit 5 key-ready (read-only, a registered copy of `core_key_ready`), bit 6 pending (read-only). `core_key_stable` and `core_data_stable` follow bits 3 and 4 from the cycle after the write. A write to any key offset clears bit 3.
- R4: Writing bit 0 asserts `core_enc` from the next cycle. Writing bit 1 alone asserts `core_dec`. When both bits are written, only `core_enc` rises. The request holds until `core_done`, and it is low in the cycle after that pulse.
- R5: On `core_done`, `core_dout` word i is captured into offset 12+i. The result area ignores writes. Reads do not clear it. It changes only on the next `core_done`.
- R6: `core_done` sets the pending bit. `irq` is high from the cycle after the pulse when interrupt enable is set, and stays low when it is clear. Any control-word write clears the pending bit and `irq`.
- R7: Read data appears on `bus_rdata` exactly one cycle after `bus_rd`. `bus_rdata` is 0 in every cycle that does not follow a read. Offsets 17 and above read as 0.
- R8: With DEC_EN = 0, bit 1 of a control write is ignored, reads as 0, and `core_dec` never asserts.
- R9: After reset, every register, every core-facing output, `irq` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Word offset of the transfer |
| bus_wr | input | 1 | Write strobe, one word |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one word |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| irq | output | 1 | Completion interrupt, level high |
| core_key | output | 32*KEY_WORDS | Key words, word 0 in the low bits |
| core_din | output | 128 | Input block, word 0 in the low bits |
| core_key_stable | output | 1 | Key-stable flag to the engine |
| core_data_stable | output | 1 | Data-stable flag to the engine |
| core_enc | output | 1 | Encrypt request |
| core_dec | output | 1 | Decrypt request |
| core_key_ready | input | 1 | Engine reports expanded keys ready |
| core_done | input | 1 | One-cycle completion pulse |
| core_dout | input | 128 | Engine output block, word 0 in the low bits |

## Verification
The bench builds two copies of the block on the same bus and the same engine stub. The first uses six key words and has the decrypt path. It exercises the key words that lie in the key span but beyond the key length, the encrypt-over-decrypt priority, and both the interrupt and the polling completion paths. The second uses four key words and has no decrypt path. It shows that a decrypt request written to it has no effect at its ports and in its control word, while the first copy accepts the same write.

// File: rtl/cipher_slave_pkg.sv
package cipher_slave_pkg;
   localparam int WORD_W    = 32;
   localparam int BLK_WORDS = 4;
   localparam int BLK_W     = WORD_W * BLK_WORDS;
   localparam int KEY_SPAN  = 8;

   // word offsets of the register window
   localparam int KEY_BASE  = 0;
   localparam int DIN_BASE  = 8;
   localparam int RES_BASE  = 12;
   localparam int CTRL_OFS  = 16;

   // control word bit positions
   localparam int CB_ENC  = 0;
   localparam int CB_DEC  = 1;
   localparam int CB_IEN  = 2;
   localparam int CB_KSTB = 3;
   localparam int CB_DSTB = 4;
   localparam int CB_KRDY = 5;
   localparam int CB_PEND = 6;
   localparam int CB_W    = 5;   // writable bits

   typedef struct packed {
      logic dstb;
      logic kstb;
      logic ien;
      logic dec;
      logic enc;
   } ctrl_t;
endpackage

// File: rtl/cs_word_bank.sv
module cs_word_bank import cipher_slave_pkg::*; #(
   parameter int N_WORDS = 4,
   parameter int BASE    = 0,
   parameter int ADDR_W  = 5
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [WORD_W-1:0]         wr_data,
   output logic [N_WORDS*WORD_W-1:0] words_o,
   output logic                      hit_o
);
   localparam int REL_W = ADDR_W + 1;

   if (N_WORDS < 1 || BASE + N_WORDS > (1 << ADDR_W)) begin : g_bad_range
      $error("cs_word_bank: window does not fit the address space");
   end

   for (genvar i = 0; i < N_WORDS; i++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(BASE + i))
            q <= wr_data;
      end
      assign words_o[i*WORD_W +: WORD_W] = q;
   end

   // offset relative to the window base; wraps high when below it
   logic [REL_W-1:0] rel;
   always_comb begin
      rel   = {1'b0, wr_addr} - REL_W'(BASE);
      hit_o = wr_en && (rel < REL_W'(N_WORDS));
   end
endmodule

// File: rtl/cs_result_bank.sv
module cs_result_bank import cipher_slave_pkg::*; #(
   parameter int N_WORDS = BLK_WORDS
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      load,
   input  logic [N_WORDS*WORD_W-1:0] load_data,
   output logic [N_WORDS*WORD_W-1:0] words_o
);
   if (N_WORDS < 1) begin : g_bad_size
      $error("cs_result_bank: needs at least one word");
   end

   always_ff @(posedge clk) begin
      if (rst)
         words_o <= '0;
      else if (load)
         words_o <= load_data;
   end
endmodule

// File: rtl/cs_ctrl_word.sv
module cs_ctrl_word import cipher_slave_pkg::*; #(
   parameter bit DEC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctrl_wr,
   input  logic [CB_W-1:0]   cmd_bits,
   input  logic              key_touch,
   input  logic              data_touch,
   input  logic              core_done,
   input  logic              key_ready_i,
   output logic              enc_o,
   output logic              dec_o,
   output logic              kstb_o,
   output logic              dstb_o,
   output logic              irq_o,
   output logic [WORD_W-1:0] rd_word_o
);
   ctrl_t cur, nxt, nxt_f;
   logic  pend_q, pend_n;
   logic  krdy_q, irq_q;
   logic  dec_allow;

   always_comb begin
      nxt    = cur;
      pend_n = pend_q;
      if (ctrl_wr) begin
         nxt.enc  = cmd_bits[CB_ENC];
         nxt.dec  = cmd_bits[CB_DEC] & ~cmd_bits[CB_ENC];
         nxt.ien  = cmd_bits[CB_IEN];
         nxt.kstb = cmd_bits[CB_KSTB];
         nxt.dstb = cmd_bits[CB_DSTB];
         pend_n   = 1'b0;
      end else if (core_done) begin
         nxt.enc = 1'b0;
         nxt.dec = 1'b0;
      end
      if (key_touch)  nxt.kstb = 1'b0;
      if (data_touch) nxt.dstb = 1'b0;
      if (core_done)  pend_n   = 1'b1;
   end

   if (DEC_EN) begin : g_dec
      always_comb dec_allow = nxt.dec;
   end else begin : g_no_dec
      always_comb dec_allow = 1'b0;
   end

   always_comb begin
      nxt_f     = nxt;
      nxt_f.dec = dec_allow;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cur    <= '0;
         pend_q <= 1'b0;
         krdy_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         cur    <= nxt_f;
         pend_q <= pend_n;
         krdy_q <= key_ready_i;
         irq_q  <= pend_n & nxt_f.ien;
      end
   end

   always_comb begin
      rd_word_o          = '0;
      rd_word_o[CB_ENC]  = cur.enc;
      rd_word_o[CB_DEC]  = cur.dec;
      rd_word_o[CB_IEN]  = cur.ien;
      rd_word_o[CB_KSTB] = cur.kstb;
      rd_word_o[CB_DSTB] = cur.dstb;
      rd_word_o[CB_KRDY] = krdy_q;
      rd_word_o[CB_PEND] = pend_q;
   end

   assign enc_o  = cur.enc;
   assign dec_o  = cur.dec;
   assign kstb_o = cur.kstb;
   assign dstb_o = cur.dstb;
   assign irq_o  = irq_q;
endmodule

// File: rtl/cipher_reg_slave.sv
module cipher_reg_slave import cipher_slave_pkg::*; #(
   parameter int KEY_WORDS = 8,
   parameter bit DEC_EN    = 1'b1,
   parameter int ADDR_W    = 5
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_wr,
   input  logic [WORD_W-1:0]           bus_wdata,
   input  logic                        bus_rd,
   output logic [WORD_W-1:0]           bus_rdata,
   output logic                        irq,
   output logic [KEY_WORDS*WORD_W-1:0] core_key,
   output logic [BLK_W-1:0]            core_din,
   output logic                        core_key_stable,
   output logic                        core_data_stable,
   output logic                        core_enc,
   output logic                        core_dec,
   input  logic                        core_key_ready,
   input  logic                        core_done,
   input  logic [BLK_W-1:0]            core_dout
);
   localparam int KEY_W = KEY_WORDS * WORD_W;

   if (KEY_WORDS != 4 && KEY_WORDS != 6 && KEY_WORDS != 8) begin : g_bad_key
      $error("cipher_reg_slave: KEY_WORDS must be 4, 6 or 8");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("cipher_reg_slave: ADDR_W must reach offset 16");
   end

   logic [KEY_W-1:0]  key_q;
   logic [BLK_W-1:0]  din_q;
   logic [BLK_W-1:0]  res_q;
   logic [WORD_W-1:0] ctrl_rd;
   logic              key_hit, din_hit, ctrl_wr, ctrl_ien;
   logic [WORD_W-1:0] rd_next;

   assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
   assign ctrl_ien = ctrl_rd[CB_IEN];

   cs_word_bank #(.N_WORDS(KEY_WORDS), .BASE(KEY_BASE), .ADDR_W(ADDR_W)) u_key (
      .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_addr(bus_addr),
      .wr_data(bus_wdata), .words_o(key_q), .hit_o(key_hit));

   cs_word_bank #(.N_WORDS(BLK_WORDS), .BASE(DIN_BASE), .ADDR_W(ADDR_W)) u_din (
      .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_addr(bus_addr),
      .wr_data(bus_wdata), .words_o(din_q), .hit_o(din_hit));

   cs_result_bank #(.N_WORDS(BLK_WORDS)) u_res (
      .clk(clk), .rst(rst), .load(core_done), .load_data(core_dout),
      .words_o(res_q));

   cs_ctrl_word #(.DEC_EN(DEC_EN)) u_ctrl (
      .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .cmd_bits(bus_wdata[CB_W-1:0]),
      .key_touch(key_hit), .data_touch(din_hit), .core_done(core_done),
      .key_ready_i(core_key_ready), .enc_o(core_enc), .dec_o(core_dec),
      .kstb_o(core_key_stable), .dstb_o(core_data_stable), .irq_o(irq),
      .rd_word_o(ctrl_rd));

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < KEY_WORDS; i++)
         if (bus_addr == ADDR_W'(KEY_BASE + i)) rd_next = key_q[i*WORD_W +: WORD_W];
      for (int i = 0; i < BLK_WORDS; i++) begin
         if (bus_addr == ADDR_W'(DIN_BASE + i)) rd_next = din_q[i*WORD_W +: WORD_W];
         if (bus_addr == ADDR_W'(RES_BASE + i)) rd_next = res_q[i*WORD_W +: WORD_W];
      end
      if (bus_addr == ADDR_W'(CTRL_OFS)) rd_next = ctrl_rd;
   end

   always_ff @(posedge clk) begin
      if (rst)
         bus_rdata <= '0;
      else
         bus_rdata <= bus_rd ? rd_next : '0;
   end

   assign core_key = key_q;
   assign core_din = din_q;
endmodule

// File: rtl/cipher_reg_slave_chk.sv
module cipher_reg_slave_chk import cipher_slave_pkg::*; #(
   parameter int ADDR_W = 5,
   parameter bit DEC_EN = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [WORD_W-1:0] bus_rdata,
   input logic              irq,
   input logic              core_enc,
   input logic              core_dec,
   input logic              core_done,
   input logic              irq_en,
   input logic [BLK_W-1:0]  res_words
);
   logic ctrl_wr;
   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));

   // R4: never both requests at once
   p_req_onehot_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0({core_enc, core_dec}));

   // R4: completion drops the request
   p_done_clears_r4: assert property (@(posedge clk) disable iff (rst)
      (core_done && !ctrl_wr) |=> (!core_enc && !core_dec));

   // R6: completion with interrupt enabled raises irq
   p_irq_raise_r6: assert property (@(posedge clk) disable iff (rst)
      (core_done && irq_en && !ctrl_wr) |=> irq);

   // R6: a control write acknowledges
   p_irq_ack_r6: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr && !core_done) |=> !irq);

   // R5: results change only on completion
   p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !core_done |=> $stable(res_words));

   // R7: read data bus is quiet outside read responses
   p_idle_rdata_r7: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |=> (bus_rdata == '0));

   if (!DEC_EN) begin : g_no_dec
      // R8: no decrypt request without the decrypt path
      p_no_dec_r8: assert property (@(posedge clk) disable iff (rst) !core_dec);
   end
endmodule

bind cipher_reg_slave cipher_reg_slave_chk #(.ADDR_W(ADDR_W), .DEC_EN(DEC_EN)) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_rdata(bus_rdata), .irq(irq), .core_enc(core_enc), .core_dec(core_dec),
   .core_done(core_done), .irq_en(ctrl_ien), .res_words(res_q));

// File: tb/cipher_reg_slave_test.sv
module cipher_reg_slave_test;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [4:0]   bus_addr = '0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic         core_key_ready = 1'b0, core_done = 1'b0;
   logic [127:0] core_dout = '0;

   logic [31:0]  rdata_m, rdata_l;
   logic         irq_m, irq_l, kst_m, kst_l, dst_m, dst_l, enc_m, enc_l, dec_m, dec_l;
   logic [191:0] key_m;
   logic [127:0] key_l, din_m, din_l;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   cipher_reg_slave #(.KEY_WORDS(6), .DEC_EN(1'b1), .ADDR_W(5)) uut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(rdata_m), .irq(irq_m), .core_key(key_m), .core_din(din_m),
      .core_key_stable(kst_m), .core_data_stable(dst_m), .core_enc(enc_m), .core_dec(dec_m),
      .core_key_ready(core_key_ready), .core_done(core_done), .core_dout(core_dout));

   cipher_reg_slave #(.KEY_WORDS(4), .DEC_EN(1'b0), .ADDR_W(5)) uut_lite (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(rdata_l), .irq(irq_l), .core_key(key_l), .core_din(din_l),
      .core_key_stable(kst_l), .core_data_stable(dst_l), .core_enc(enc_l), .core_dec(dec_l),
      .core_key_ready(core_key_ready), .core_done(core_done), .core_dout(core_dout));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_w(input string req, input logic [191:0] act, input logic [191:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int a, output logic [31:0] dm, output logic [31:0] dl);
      @(negedge clk);
      bus_addr = 5'(a); bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      dm = rdata_m; dl = rdata_l;
   endtask

   task automatic finish_op(input logic [127:0] res);
      @(negedge clk);
      core_dout = res; core_done = 1'b1;
      @(negedge clk);
      core_done = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] dm, dl;
      chk("R9 enc", 32'(enc_m), 32'h0);
      chk("R9 irq", 32'(irq_m), 32'h0);
      chk_w("R9 key", key_m, 192'h0);
      chk("R9 rdata", rdata_m, 32'h0);
      bus_read(16, dm, dl);
      chk("R9 ctrl", dm, 32'h0);
   endtask

   task automatic t_key;
      logic [191:0] exp6 = '0;
      logic [127:0] exp4 = '0;
      logic [31:0] dm, dl;
      for (int i = 0; i < 8; i++) begin
         bus_write(i, 32'hA500_0000 | 32'(i));
         if (i < 6) exp6[i*32 +: 32] = 32'hA500_0000 | 32'(i);
         if (i < 4) exp4[i*32 +: 32] = 32'hA500_0000 | 32'(i);
      end
      chk_w("R1 key six words", key_m, exp6);
      chk_w("R1 key four words", 192'(key_l), 192'(exp4));
      bus_read(4, dm, dl);
      chk("R1 readback word 4", dm, 32'hA500_0004);
      chk("R1 beyond key length lite", dl, 32'h0);
      bus_read(6, dm, dl);
      chk("R1 beyond key length", dm, 32'h0);
      bus_write(16, 32'h08);
      chk("R3 key stable set", 32'(kst_m), 32'h1);
      bus_write(1, 32'h1111_1111);
      chk("R3 key write clears key stable", 32'(kst_m), 32'h0);
      chk("R1 key word 1 updated", key_m[63:32], 32'h1111_1111);
   endtask

   task automatic t_data;
      logic [127:0] exp = '0;
      logic [31:0] dm, dl;
      for (int i = 0; i < 4; i++) begin
         bus_write(8 + i, 32'hD000_0000 | 32'(i));
         exp[i*32 +: 32] = 32'hD000_0000 | 32'(i);
      end
      chk_w("R2 core_din", 192'(din_m), 192'(exp));
      bus_read(10, dm, dl);
      chk("R2 readback", dm, 32'hD000_0002);
      bus_write(16, 32'h18);
      chk("R3 data stable set", 32'(dst_m), 32'h1);
      bus_write(9, 32'hD000_0001);
      chk("R2 data write clears data stable", 32'(dst_m), 32'h0);
      chk("R2 key stable untouched", 32'(kst_m), 32'h1);
   endtask

   task automatic t_ctrl;
      logic [31:0] dm, dl;
      core_key_ready = 1'b1;
      bus_write(16, 32'h1C);
      bus_read(16, dm, dl);
      chk("R3 ctrl readback with key ready", dm, 32'h3C);
      chk("R3 flags out", {30'h0, kst_m, dst_m}, 32'h3);
   endtask

   task automatic t_encrypt;
      logic [127:0] res = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
      logic [31:0] dm, dl;
      bus_write(16, 32'h1D);
      chk("R4 enc request", {30'h0, enc_m, dec_m}, 32'h2);
      repeat (3) @(negedge clk);
      chk("R4 enc held", 32'(enc_m), 32'h1);
      finish_op(res);
      chk("R4 enc self-clear", 32'(enc_m), 32'h0);
      chk("R6 irq on completion", 32'(irq_m), 32'h1);
      bus_read(16, dm, dl);
      chk("R6 ctrl after completion", dm, 32'h7C);
      for (int i = 0; i < 4; i++) begin
         bus_read(12 + i, dm, dl);
         chk("R5 result word", dm, res[i*32 +: 32]);
      end
      bus_read(13, dm, dl);
      chk("R5 result kept after read", dm, res[63:32]);
      bus_write(12, 32'hBAD0_BAD0);
      bus_read(12, dm, dl);
      chk("R5 result write ignored", dm, res[31:0]);
      chk("R6 irq holds until ctrl write", 32'(irq_m), 32'h1);
      bus_write(16, 32'h1C);
      chk("R6 irq acknowledged", 32'(irq_m), 32'h0);
      bus_read(16, dm, dl);
      chk("R6 pending cleared", dm, 32'h3C);
   endtask

   task automatic t_decrypt;
      logic [127:0] res = 128'hCAFE_0003_CAFE_0002_CAFE_0001_CAFE_0000;
      logic [31:0] dm, dl;
      bus_write(16, 32'h1E);
      chk("R4 dec request", {30'h0, enc_m, dec_m}, 32'h1);
      chk("R8 lite ignores dec", 32'(dec_l), 32'h0);
      bus_read(16, dm, dl);
      chk("R4 ctrl dec bit", dm, 32'h3E);
      chk("R8 lite dec bit reads 0", dl, 32'h3C);
      finish_op(res);
      chk("R4 dec self-clear", 32'(dec_m), 32'h0);
      bus_read(15, dm, dl);
      chk("R5 dec result", dm, 32'hCAFE_0003);
      bus_write(16, 32'h1F);
      chk("R4 enc wins over dec", {30'h0, enc_m, dec_m}, 32'h2);
      finish_op(128'h0);
      bus_write(16, 32'h18);
   endtask

   task automatic t_poll;
      logic [31:0] dm, dl;
      bus_write(16, 32'h19);
      chk("R4 enc for poll", 32'(enc_m), 32'h1);
      finish_op(128'h5);
      chk("R6 no irq when disabled", 32'(irq_m), 32'h0);
      bus_read(16, dm, dl);
      chk("R6 pending by polling", dm, 32'h78);
   endtask

   task automatic t_read;
      logic [31:0] dm, dl;
      bus_read(20, dm, dl);
      chk("R7 unmapped reads 0", dm, 32'h0);
      bus_read(31, dm, dl);
      chk("R7 top offset reads 0", dm, 32'h0);
      bus_read(8, dm, dl);
      chk("R7 one-cycle latency", dm, 32'hD000_0000);
      @(negedge clk);
      chk("R7 rdata returns to 0", rdata_m, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_key();
      t_data();
      t_ctrl();
      t_encrypt();
      t_decrypt();
      t_poll();
      t_read();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule